// File: doc/BRIEF.md
# Paged Register Write Sequencer

The sequencer takes one 32-bit register write from a host and turns it into three 16-bit write transactions on a clause-22 style management bus. The first transaction selects a page on a fixed PHY address. After a settle interval, the two halves of the data word go out on a PHY address and register pair that are derived from the remaining register address bits. A strap input selects which half is written first, because some attached devices need the low half before the high half.

On the host side, a request is transferred when `req_valid` and `req_ready` are both high on a clock edge. The block holds `req_ready` low until the last bus transaction of the sequence has completed, so the host must keep its request stable and wait. On the bus side, the block presents one transaction at a time with `bus_valid` and holds it until the bus engine returns `bus_done`. The bus engine applies back-pressure simply by delaying `bus_done`. The bit-level serialisation of MDC and MDIO is handled outside this block.

Top module: `paged_wr_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `req_ready` is 1, `bus_valid` is 0 and `busy` is 0.
- R2: The first transaction after a request is accepted is a page write with `bus_phy`=0x18, `bus_regn`=0 and `bus_wdata` set to address bits [18:9], zero-extended to 16 bits.
- R3: Both data writes use `bus_phy` = 0x10 OR address bits [8:6]. The low half goes to register {addr[5:2],0} and the high half goes to that register number plus one. Address bits [1:0] have no effect.
- R4: Between the cycle in which the page write completes and the first data write, `bus_valid` stays low for exactly SETTLE_CYC cycles.
- R5: With `lo_first`=0, the high half (data[31:16]) is written before the low half (data[15:0]).
- R6: With `lo_first`=1, the low half is written before the high half. The strap is sampled when the request is accepted, and later changes do not affect a sequence already running.
- R7: Each transaction's PHY, register and data stay stable while `bus_valid` is high, until an edge at which `bus_done` is high. The sequencer advances on that edge.
- R8: From the edge that accepts a request until the edge that completes the last data write, `req_ready` is 0 and `busy` is 1. After that edge, `req_ready` is 1 again.
- R9: A `bus_done` pulse while `bus_valid` is low has no effect. When idle, it leaves the block idle. During the settle interval, it does not shorten the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_first | input | 1 | Order strap: 1 writes the low half first |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request ready (high only when idle) |
| req_addr | input | ADDR_W | Register address of the wide write |
| req_data | input | 32 | Write data |
| bus_valid | output | 1 | Bus transaction presented |
| bus_phy | output | 5 | PHY address of the transaction |
| bus_regn | output | 5 | Register number of the transaction |
| bus_wdata | output | 16 | 16-bit write data |
| bus_done | input | 1 | Bus engine finished the presented transaction |
| busy | output | 1 | A sequence is in progress |

## Verification
The bench varies the bus response latency from zero to several cycles. A design that advanced early, or changed fields mid-transaction, would present a transaction the scoreboard does not expect. It measures the quiet gap after each page write, so an off-by-one settle counter shows up as a gap of SETTLE_CYC±1. It also injects a stray `bus_done` both while idle and in the middle of the settle gap; a design that reacted to these would either start a phantom sequence or cut the gap short. It flips the order strap in the middle of a sequence, which catches a design that reads the strap live instead of latching it at acceptance. Finally, it uses addresses with bits [1:0] set, which expose any leak of those bits into the register number.

// File: rtl/pws_pkg.sv
package pws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAGE,
    ST_SETTLE,
    ST_FIRST,
    ST_SECOND
  } seq_state_e;

  typedef struct packed {
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] data;
  } bus_txn_t;

endpackage

// File: rtl/pws_slice.sv
// Derives the three bus transactions from a latched wide write.
module pws_slice
  import pws_pkg::*;
#(
  parameter int          ADDR_W    = 19,
  parameter logic [4:0]  PAGE_PHY  = 5'h18,
  parameter logic [4:0]  DATA_PHY  = 5'h10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       data,
  input  logic              lo_first,
  output bus_txn_t          page_txn,
  output bus_txn_t          first_txn,
  output bus_txn_t          second_txn
);
  localparam int PAGE_LSB = 9;
  localparam int PAGE_W   = ADDR_W - PAGE_LSB;

  logic [PAGE_W-1:0] page_bits;
  logic [4:0]        lo_reg;
  logic [4:0]        hi_reg;
  logic [4:0]        sub_phy;
  bus_txn_t          lo_txn;
  bus_txn_t          hi_txn;

  always_comb begin
    page_bits = addr[ADDR_W-1:PAGE_LSB];
    lo_reg    = {addr[5:2], 1'b0};
    hi_reg    = {addr[5:2], 1'b1};
    sub_phy   = DATA_PHY | {2'b00, addr[8:6]};

    page_txn.phy  = PAGE_PHY;
    page_txn.regn = 5'd0;
    page_txn.data = 16'(page_bits);

    lo_txn.phy  = sub_phy;
    lo_txn.regn = lo_reg;
    lo_txn.data = data[15:0];

    hi_txn.phy  = sub_phy;
    hi_txn.regn = hi_reg;
    hi_txn.data = data[31:16];

    first_txn  = lo_first ? lo_txn : hi_txn;
    second_txn = lo_first ? hi_txn : lo_txn;
  end
endmodule

// File: rtl/pws_settle.sv
// Counts the quiet interval after the page write.
module pws_settle #(
  parameter int SETTLE_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start)
      cnt_q <= LOAD;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == CNT_W'(1));

  // R4: the counter never runs past its load value
  a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);
endmodule

// File: rtl/pws_ctrl.sv
// Sequencing state machine: request latch, transaction select, settle gap.
module pws_ctrl
  import pws_pkg::*;
#(
  parameter int         ADDR_W     = 19,
  parameter int         SETTLE_CYC = 50000,
  parameter logic [4:0] PAGE_PHY   = 5'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_data,
  input  logic              lo_first,
  input  logic              bus_done,
  input  logic              settle_expire,
  output logic              settle_start,
  input  bus_txn_t          page_txn,
  input  bus_txn_t          first_txn,
  input  bus_txn_t          second_txn,
  output logic              bus_valid,
  output bus_txn_t          bus_txn,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [31:0]       lat_data,
  output logic              lat_lo,
  output logic              busy
);
  localparam int GAP_W = $clog2(SETTLE_CYC + 1);

  seq_state_e state_q, state_d;
  logic       accept;

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid)     state_d = ST_PAGE;
      ST_PAGE:   if (bus_done)      state_d = ST_SETTLE;
      ST_SETTLE: if (settle_expire) state_d = ST_FIRST;
      ST_FIRST:  if (bus_done)      state_d = ST_SECOND;
      ST_SECOND: if (bus_done)      state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  assign settle_start = (state_q == ST_PAGE) && bus_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      lat_addr <= '0;
      lat_data <= '0;
      lat_lo   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        lat_addr <= req_addr;
        lat_data <= req_data;
        lat_lo   <= lo_first;
      end
    end
  end

  always_comb begin
    bus_valid = 1'b1;
    bus_txn   = page_txn;
    unique case (state_q)
      ST_PAGE:   bus_txn = page_txn;
      ST_FIRST:  bus_txn = first_txn;
      ST_SECOND: bus_txn = second_txn;
      default: begin
        bus_valid = 1'b0;
        bus_txn   = page_txn;
      end
    endcase
  end

  // Gap length observer for the settle assertion
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n || state_q != ST_SETTLE)
      gap_q <= '0;
    else
      gap_q <= gap_q + 1'b1;
  end

  // R4: leaving the settle state happens after exactly SETTLE_CYC cycles in it
  a_r4_settle_len: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE && settle_expire) |-> gap_q == GAP_W'(SETTLE_CYC - 1));

  // R2: acceptance is followed by the page write
  a_r2_page_first: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> bus_valid && bus_txn.phy == PAGE_PHY && bus_txn.regn == 5'd0);

  // R7: a presented transaction holds until done
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_done) |=> bus_valid && $stable(bus_txn));

  // R8: no second request can be taken right after one is accepted
  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready && busy);

  // R9: done while idle leaves the block idle
  a_r9_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid && bus_done) |=> req_ready && !bus_valid);
endmodule

// File: rtl/paged_wr_seq.sv
module paged_wr_seq
  import pws_pkg::*;
#(
  parameter int         ADDR_W     = 19,
  parameter int         SETTLE_CYC = 50000,
  parameter logic [4:0] PAGE_PHY   = 5'h18,
  parameter logic [4:0] DATA_PHY   = 5'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_first,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_data,
  output logic              bus_valid,
  output logic [4:0]        bus_phy,
  output logic [4:0]        bus_regn,
  output logic [15:0]       bus_wdata,
  input  logic              bus_done,
  output logic              busy
);
  logic [ADDR_W-1:0] lat_addr;
  logic [31:0]       lat_data;
  logic              lat_lo;
  bus_txn_t          page_txn, first_txn, second_txn, bus_txn;
  logic              settle_start, settle_expire;

  pws_slice #(
    .ADDR_W(ADDR_W), .PAGE_PHY(PAGE_PHY), .DATA_PHY(DATA_PHY)
  ) u_slice (
    .addr(lat_addr), .data(lat_data), .lo_first(lat_lo),
    .page_txn(page_txn), .first_txn(first_txn), .second_txn(second_txn)
  );

  pws_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(settle_start), .expire(settle_expire)
  );

  pws_ctrl #(
    .ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC), .PAGE_PHY(PAGE_PHY)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .lo_first(lo_first),
    .bus_done(bus_done), .settle_expire(settle_expire), .settle_start(settle_start),
    .page_txn(page_txn), .first_txn(first_txn), .second_txn(second_txn),
    .bus_valid(bus_valid), .bus_txn(bus_txn),
    .lat_addr(lat_addr), .lat_data(lat_data), .lat_lo(lat_lo),
    .busy(busy)
  );

  assign bus_phy   = bus_txn.phy;
  assign bus_regn  = bus_txn.regn;
  assign bus_wdata = bus_txn.data;
endmodule

// File: tb/paged_wr_seq_bench.sv
module paged_wr_seq_bench;
  localparam int ADDR_W = 19;
  localparam int SETTLE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_first = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic bus_valid;
  logic [4:0] bus_phy, bus_regn;
  logic [15:0] bus_wdata;
  logic resp_done = 1'b0, spur_done = 1'b0;
  logic bus_done;
  logic busy;
  logic spur_gap = 1'b0;

  assign bus_done = resp_done | spur_done;

  int checks = 0;
  int errors = 0;
  int txn_n = 0;
  logic [25:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  paged_wr_seq #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE)) u_paged_wr_seq (
    .clk(clk), .rst_n(rst_n), .lo_first(lo_first),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data),
    .bus_valid(bus_valid), .bus_phy(bus_phy), .bus_regn(bus_regn),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: push the expected transactions, then hand the request over.
  task automatic send(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                      input logic lo, input bit flip_after);
    logic [4:0] phy, rlo;
    logic [25:0] lo_t, hi_t;
    phy  = 5'h10 | {2'b00, a[8:6]};
    rlo  = {a[5:2], 1'b0};
    lo_t = {phy, rlo, d[15:0]};
    hi_t = {phy, rlo | 5'd1, d[31:16]};
    exp_q.push_back({5'h18, 5'd0, 16'(a[ADDR_W-1:9])}); tag_q.push_back("R2");
    if (lo) begin
      exp_q.push_back(lo_t); tag_q.push_back("R6");
      exp_q.push_back(hi_t); tag_q.push_back("R6");
    end else begin
      exp_q.push_back(hi_t); tag_q.push_back("R5");
      exp_q.push_back(lo_t); tag_q.push_back("R5");
    end
    @(negedge clk);
    req_addr = a; req_data = d; lo_first = lo; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready && busy, "R8", "ready/busy after accept", {30'd0, req_ready, busy}, 32'h1);
    if (flip_after) lo_first = ~lo;
  endtask

  // Monitor/responder: compare each presented transaction, then complete it.
  initial begin
    logic [25:0] seen, exp;
    string tag;
    int gap;
    forever begin
      @(negedge clk);
      if (bus_valid && rst_n) begin
        seen = {bus_phy, bus_regn, bus_wdata};
        repeat (txn_n % 4) begin
          @(negedge clk);
          check({bus_phy, bus_regn, bus_wdata} == seen && bus_valid, "R7",
                "hold while waiting", 32'({bus_phy, bus_regn, bus_wdata}), 32'(seen));
        end
        txn_n++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected transaction", 32'(seen), 32'h0);
        end else begin
          exp = exp_q.pop_front();
          tag = tag_q.pop_front();
          check(seen == exp, tag, "transaction", 32'(seen), 32'(exp));
          if (tag != "R2")
            check(seen[20:16] == exp[20:16] && seen[25:21] == exp[25:21], "R3",
                  "data phy/reg", 32'(seen[25:16]), 32'(exp[25:16]));
        end
        check(!req_ready && busy, "R8", "busy during transaction", {30'd0, req_ready, busy}, 32'h1);
        resp_done = 1'b1;
        @(negedge clk);
        resp_done = 1'b0;
        if (seen[25:21] == 5'h18) begin
          gap = 0;
          while (!bus_valid) begin
            gap++;
            if (gap == 3 && spur_gap) resp_done = 1'b1; else resp_done = 1'b0;
            @(negedge clk);
          end
          resp_done = 1'b0;
          check(gap == SETTLE, spur_gap ? "R9" : "R4", "settle gap", 32'(gap), 32'(SETTLE));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    check(req_ready && !bus_valid, "R8", "ready after last done", {30'd0, req_ready, bus_valid}, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !bus_valid && !busy, "R1", "in reset", {29'd0, req_ready, bus_valid, busy}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !bus_valid && !busy, "R1", "after reset", {29'd0, req_ready, bus_valid, busy}, 32'h4);

    // R9: stray done while idle
    spur_done = 1'b1; @(negedge clk); spur_done = 1'b0; @(negedge clk);
    check(!busy && !bus_valid && req_ready, "R9", "idle after stray done", {30'd0, busy, bus_valid}, 32'h0);

    send(19'h5A5A7, 32'hDEADBEEF, 1'b0, 1'b0); wait_idle();       // R5, R3 bits[1:0] set
    send(19'h7FFFF, 32'h12345678, 1'b1, 1'b0); wait_idle();       // R6
    send(19'h00000, 32'h0000FFFF, 1'b1, 1'b1); wait_idle();       // R6 strap flipped mid-run
    send(19'h3C1C2, 32'hA5A55A5A, 1'b0, 1'b1); wait_idle();       // R5 strap flipped mid-run
    spur_gap = 1'b1;
    send(19'h401C0, 32'hCAFEF00D, 1'b0, 1'b0); wait_idle();       // R9 done inside settle
    spur_gap = 1'b0;
    send(19'h2AAAB, 32'h80000001, 1'b1, 1'b0);                    // back-to-back
    send(19'h15554, 32'h7FFFFFFE, 1'b0, 1'b0); wait_idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule